// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter reached through an 8-bit register bus. It counts one of two sources. The first is an internal instruction-cycle tick at one quarter of the system clock. The second is the rising edges of an external clock pin, and that pin can pass through a two-flop synchroniser or feed a bare edge detector. A power-of-two prescaler divides the chosen source, and a run bit gates counting.

When the count wraps from 0xFFFF to 0x0000 a sticky overflow flag is raised. A one-cycle trigger pulse from a compare unit clears the count. An optional buffered-high-byte mode makes 16-bit reads and writes coherent across two 8-bit accesses.

Register map (2-bit address):

- Address 0 is control. Bit 0 is run. Bit 1 selects the external source. Bit 2 selects the synchronised external path. Bits 4:3 hold the prescaler exponent. Bit 5 turns on the buffered 16-bit mode. Bits 7:6 always read 0.
- Address 1 is the low count byte.
- Address 2 is the high count byte, or the buffer when the buffered mode is on.
- Address 3 is the flag register, with the overflow flag in bit 0.

Top module: `pstimer16`

## Requirements
- R1: After reset, all four addresses read 0x00 and `irq_flag` is 0.
- R2: With control bit 1 = 0 and an exponent of 0, the count advances exactly once every 4 system clocks.
- R3: A prescaler exponent p in control bits 4:3 makes the count advance once per 2^p source ticks (internal or external).
- R4: With control bits 1 and 2 both set, each rising edge of `ext_clk` advances the count exactly once. The new value appears on the third clock edge after the pin rises.
- R5: With control bit 1 set and bit 2 clear, each rising edge of `ext_clk` advances the count once. The new value appears on the first clock edge after the pin rises.
- R6: With control bit 0 = 0, the count and the prescaler hold their values.
- R7: Wrapping from 0xFFFF to 0x0000 sets the flag (address 3 bit 0 and `irq_flag`) on the same edge as the wrap. The flag stays set. Writing 0 to bit 0 clears it, and writing 1 has no effect.
- R8: A `clr_trig` pulse sets the count to 0x0000 and restarts the prescaler. It takes priority over a bus write and over an increment in the same cycle.
- R9: With control bit 5 = 0, addresses 1 and 2 read and write the low and high count bytes directly.
- R10: With control bit 5 = 1, a read of address 1 copies the current high count byte into the buffer, and address 2 then reads that buffer.
- R11: With control bit 5 = 1, a write to address 2 changes only the buffer. A write to address 1 loads the buffer and the written byte into the count together.
- R12: A write that changes the count restarts the prescaler, so the next increment comes a full 2^p source ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (has a side effect: buffer capture) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| ext_clk | input | 1 | External count clock |
| clr_trig | input | 1 | Count clear trigger, one cycle wide |
| irq_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest situation to reach from the ports is a buffered read that straddles a carry from the low byte into the high byte. The capture and the later read of the high byte must disagree with the live count. To get there, the stimulus preloads 0x01FE in buffered mode and polls the low byte without the read strobe until it shows 0xFF. It then issues the capturing read in that same cycle, which the 4-cycle tick spacing makes safe, and waits well past the carry before it reads the buffer. The prescaler-restart checks work the same way: they write or trigger in the middle of a divide period, so that a missing restart shows up as a short first interval.

// File: rtl/pstimer16_pkg.sv
package pstimer16_pkg;

   // Register addresses on the 2-bit bus
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_CLO  = 2'd1,
      REG_CHI  = 2'd2,
      REG_FLAG = 2'd3
   } reg_addr_e;

   // Fixed control-bit positions; the prescaler field starts at CB_PS
   localparam int CB_RUN  = 0;
   localparam int CB_SRC  = 1;
   localparam int CB_SYNC = 2;
   localparam int CB_PS   = 3;

   // Flag register bit holding the overflow state
   localparam int FB_OVF  = 0;

endpackage

// File: rtl/pstimer16_src.sv
// Source selection: internal cycle tick or external edge (synchronised or raw)
module pstimer16_src #(
   parameter int CYC_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_clk,
   input  logic src_ext,
   input  logic sync_en,
   output logic src_tick
);

   localparam int PH_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;

   logic int_tick;
   logic sync_edge;
   logic async_edge;

   // ---------------- internal instruction-cycle tick ----------------
   generate
      if (CYC_DIV == 1) begin : g_nodiv
         assign int_tick = 1'b1;
      end else begin : g_div
         logic [PH_W-1:0] phase;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            phase <= '0;
            else if (phase == PH_W'(CYC_DIV - 1))  phase <= '0;
            else                                   phase <= phase + 1'b1;
         end
         assign int_tick = (phase == PH_W'(CYC_DIV - 1));

         AST_CYC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            int_tick |=> !int_tick);  // R2
      end
   endgenerate

   // ---------------- synchronised external path ----------------
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_prev;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= ext_clk;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_prev <= 1'b0;
      else        sync_prev <= sync_q[SYNC_STAGES-1];
   end

   assign sync_edge = sync_q[SYNC_STAGES-1] & ~sync_prev;

   // ---------------- raw (unsynchronised) external path ----------------
   logic raw_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_prev <= 1'b0;
      else        raw_prev <= ext_clk;
   end

   assign async_edge = ext_clk & ~raw_prev;

   // ---------------- source mux ----------------
   always_comb begin
      if (!src_ext)     src_tick = int_tick;
      else if (sync_en) src_tick = sync_edge;
      else              src_tick = async_edge;
   end

   AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sync_edge |=> !sync_edge);  // R4

endmodule

// File: rtl/pstimer16_presc.sv
// Power-of-two prescaler on the selected source tick
module pstimer16_presc #(
   parameter int PS_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            src_tick,
   input  logic            run,
   input  logic [PS_W-1:0] ps_sel,
   input  logic            restart,
   output logic            cnt_pulse
);

   localparam int DIV_W = (1 << PS_W) - 1;

   logic [DIV_W-1:0] pcnt;
   logic [DIV_W-1:0] mask;

   assign mask = ~({DIV_W{1'b1}} << ps_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pcnt <= '0;
      else if (restart)          pcnt <= '0;
      else if (run && src_tick)  pcnt <= pcnt + 1'b1;
   end

   assign cnt_pulse = run & src_tick & ((pcnt & mask) == mask) & ~restart;

   AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !restart |=> $stable(pcnt));  // R6

   AST_PRESC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> pcnt == '0);  // R12

endmodule

// File: rtl/pstimer16_core.sv
// Count register, high-byte buffer and sticky overflow flag
module pstimer16_core #(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_pulse,
   input  logic             clr,
   input  logic             mode16,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic             rd_lo,
   input  logic [BUS_W-1:0] wdata,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count,
   output logic [BUS_W-1:0] hbuf,
   output logic             ovf
);

   localparam int HI_W = CNT_W - BUS_W;

   logic wr_hi_direct;
   logic wrap;

   assign wr_hi_direct = wr_hi & ~mode16;
   assign wrap = cnt_pulse & ~clr & ~wr_lo & ~wr_hi_direct & (&count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            count <= '0;
      else if (clr)          count <= '0;
      else if (wr_lo) begin
         if (mode16)         count <= {hbuf, wdata};
         else                count <= {count[CNT_W-1:BUS_W], wdata};
      end
      else if (wr_hi_direct) count <= {wdata, count[BUS_W-1:0]};
      else if (cnt_pulse)    count <= count + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 hbuf <= '0;
      else if (mode16 && wr_hi)   hbuf <= wdata;
      else if (mode16 && rd_lo)   hbuf <= count[CNT_W-1:BUS_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ovf <= 1'b0;
      else if (wrap)     ovf <= 1'b1;
      else if (flag_clr) ovf <= 1'b0;
   end

   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_pulse && !clr && !wr_lo && !(wr_hi && !mode16) && (count == {CNT_W{1'b1}})
      |=> ovf && (count == '0));  // R7

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf && !flag_clr |=> ovf);  // R7

   AST_TRIG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0);  // R8

   AST_BUF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      mode16 && wr_hi && !wr_lo && !clr && !cnt_pulse |=> $stable(count));  // R11

   AST_LO_LOAD16: assert property (@(posedge clk) disable iff (!rst_n)
      mode16 && wr_lo && !clr |=> count == {$past(hbuf), $past(wdata)});  // R11

   AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      mode16 && rd_lo && !wr_hi |=> hbuf == $past(count[CNT_W-1:CNT_W-HI_W]));  // R10

endmodule

// File: rtl/pstimer16.sv
// Prescaled 16-bit timer/counter behind an 8-bit register bus
module pstimer16 #(
   parameter int CNT_W       = 16,
   parameter int BUS_W       = 8,
   parameter int PS_W        = 2,
   parameter int CYC_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic             ext_clk,
   input  logic             clr_trig,
   output logic             irq_flag
);

   import pstimer16_pkg::*;

   localparam int CB_M16    = CB_PS + PS_W;
   localparam int CTRL_USED = CB_M16 + 1;
   localparam logic [BUS_W-1:0] CTRL_MASK = BUS_W'((1 << CTRL_USED) - 1);

   // ---------------- elaboration checks ----------------
   generate
      if (CNT_W != 2 * BUS_W) begin : g_chk_width
         $error("pstimer16: CNT_W must be twice BUS_W");
      end
      if (CTRL_USED > BUS_W) begin : g_chk_ctrl
         $error("pstimer16: control fields do not fit in BUS_W");
      end
      if (PS_W < 1) begin : g_chk_ps
         $error("pstimer16: PS_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("pstimer16: SYNC_STAGES must be at least 2");
      end
      if (CYC_DIV < 1) begin : g_chk_div
         $error("pstimer16: CYC_DIV must be at least 1");
      end
   endgenerate

   // ---------------- bus decode ----------------
   logic [BUS_W-1:0] ctrl;
   logic             wr_lo, wr_hi, rd_lo, flag_clr, cnt_write, restart;
   logic             run, src_ext, sync_en, mode16;
   logic [PS_W-1:0]  ps_sel;

   assign wr_lo    = bus_wr && (bus_addr == REG_CLO);
   assign wr_hi    = bus_wr && (bus_addr == REG_CHI);
   assign rd_lo    = bus_rd && !bus_wr && (bus_addr == REG_CLO);
   assign flag_clr = bus_wr && (bus_addr == REG_FLAG) && !bus_wdata[FB_OVF];

   assign run     = ctrl[CB_RUN];
   assign src_ext = ctrl[CB_SRC];
   assign sync_en = ctrl[CB_SYNC];
   assign ps_sel  = ctrl[CB_PS +: PS_W];
   assign mode16  = ctrl[CB_M16];

   assign cnt_write = wr_lo | (wr_hi & ~mode16);
   assign restart   = clr_trig | cnt_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               ctrl <= '0;
      else if (bus_wr && bus_addr == REG_CTRL)  ctrl <= bus_wdata & CTRL_MASK;
   end

   // ---------------- datapath ----------------
   logic             src_tick, cnt_pulse, ovf;
   logic [CNT_W-1:0] count;
   logic [BUS_W-1:0] hbuf;

   pstimer16_src #(
      .CYC_DIV     (CYC_DIV),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_clk  (ext_clk),
      .src_ext  (src_ext),
      .sync_en  (sync_en),
      .src_tick (src_tick)
   );

   pstimer16_presc #(
      .PS_W (PS_W)
   ) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_tick  (src_tick),
      .run       (run),
      .ps_sel    (ps_sel),
      .restart   (restart),
      .cnt_pulse (cnt_pulse)
   );

   pstimer16_core #(
      .CNT_W (CNT_W),
      .BUS_W (BUS_W)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_pulse (cnt_pulse),
      .clr       (clr_trig),
      .mode16    (mode16),
      .wr_lo     (wr_lo),
      .wr_hi     (wr_hi),
      .rd_lo     (rd_lo),
      .wdata     (bus_wdata),
      .flag_clr  (flag_clr),
      .count     (count),
      .hbuf      (hbuf),
      .ovf       (ovf)
   );

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_CTRL: bus_rdata = ctrl;
         REG_CLO:  bus_rdata = count[BUS_W-1:0];
         REG_CHI:  bus_rdata = mode16 ? hbuf : count[CNT_W-1:BUS_W];
         REG_FLAG: bus_rdata[FB_OVF] = ovf;
         default:  bus_rdata = '0;
      endcase
   end

   assign irq_flag = ovf;

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !clr_trig && !cnt_write |=> $stable(count));  // R6

   AST_FLAG_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flag && !(bus_wr && bus_addr == REG_FLAG) |=> irq_flag);  // R7

endmodule

// File: tb/pstimer16_bench.sv
module pstimer16_bench;

   localparam int PER = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ext_clk = 1'b0;
   logic       clr_trig = 1'b0;
   logic       irq_flag;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(PER/2) clk = ~clk;

   pstimer16 u_pstimer16 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ext_clk   (ext_clk),
      .clr_trig  (clr_trig),
      .irq_flag  (irq_flag)
   );

   function automatic logic [7:0] ctl(input logic run, input logic ext,
                                      input logic syn, input logic [1:0] ps,
                                      input logic m16);
      return {2'b00, m16, ps, syn, ext, run};
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_range(input string tag, input int act, input int lo, input int hi);
      total++;
      if (act < lo || act > hi) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_now(input logic [1:0] a, output logic [7:0] v);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      rd_now(a, v);
   endtask

   // direct-mode view of the count, no strobes
   task automatic peek16(output logic [15:0] v);
      bus_addr = 2'd1; #1 v[7:0] = bus_rdata;
      bus_addr = 2'd2; #1 v[15:8] = bus_rdata;
   endtask

   task automatic wait_change(output int n);
      logic [15:0] a, b;
      n = 0;
      peek16(a);
      b = a;
      while (b == a && n < 400) begin
         @(negedge clk);
         n++;
         peek16(b);
      end
   endtask

   task automatic ext_pulse();
      @(negedge clk); ext_clk = 1'b1;
      cyc(3);         ext_clk = 1'b0;
      cyc(3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0]  v8;
      logic [15:0] v;
      int          n;

      cyc(3);
      rst_n = 1'b1;
      cyc(2);

      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v8);
         chk("R1 reset register", {8'h00, v8}, 16'h0000);
      end
      chk("R1 reset irq", {15'd0, irq_flag}, 16'd0);

      // R2/R3: internal source, sweep the prescaler
      for (int p = 0; p < 4; p++) begin
         wr(2'd0, ctl(0, 0, 0, 2'(p), 0));
         wr(2'd1, 8'h00);
         wr(2'd2, 8'h00);
         wr(2'd0, ctl(1, 0, 0, 2'(p), 0));
         wait_change(n);
         for (int k = 0; k < 2; k++) begin
            wait_change(n);
            if (p == 0) chk("R2 internal interval", 16'(n), 16'd4);
            else        chk("R3 prescaled interval", 16'(n), 16'(4 << p));
         end
      end

      // R12: count write in mid-period restarts the prescaler (p=3)
      wr(2'd0, ctl(1, 0, 0, 2'd3, 0));
      wait_change(n);
      cyc(13);
      wr(2'd1, 8'h10);
      peek16(v);
      chk("R9 direct low write", v & 16'h00FF, 16'h0010);
      wait_change(n);
      chk_range("R12 restart after write", n, 29, 32);

      // R8: trigger in mid-period, same cycle as a write
      cyc(13);
      @(negedge clk);
      clr_trig = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h55; bus_wr = 1'b1;
      @(negedge clk);
      clr_trig = 1'b0; bus_wr = 1'b0;
      peek16(v);
      chk("R8 trigger clears with priority", v, 16'h0000);
      wait_change(n);
      chk_range("R8 trigger restarts prescaler", n, 29, 32);

      // R6: run bit off holds the count
      wr(2'd0, ctl(0, 0, 0, 2'd0, 0));
      wr(2'd2, 8'h12);
      wr(2'd1, 8'h34);
      cyc(50);
      peek16(v);
      chk("R6 hold while stopped", v, 16'h1234);

      // R4: synchronised external edges
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h00);
      wr(2'd0, ctl(1, 1, 1, 2'd0, 0));
      cyc(2);
      @(negedge clk); ext_clk = 1'b1;
      @(negedge clk); peek16(v); chk("R4 sync latency edge1", v, 16'd0);
      @(negedge clk); peek16(v); chk("R4 sync latency edge2", v, 16'd0);
      @(negedge clk); peek16(v); chk("R4 sync latency edge3", v, 16'd1);
      cyc(2); ext_clk = 1'b0; cyc(3);
      for (int k = 0; k < 5; k++) ext_pulse();
      cyc(4);
      peek16(v);
      chk("R4 sync edge count", v, 16'd6);

      // R3 on the external path: exponent 2, eight edges -> two counts
      wr(2'd0, ctl(1, 1, 1, 2'd2, 0));
      wr(2'd1, 8'h00);
      for (int k = 0; k < 8; k++) ext_pulse();
      cyc(4);
      peek16(v);
      chk("R3 external prescaled", v, 16'd2);

      // R5: raw external path
      wr(2'd0, ctl(1, 1, 0, 2'd0, 0));
      wr(2'd1, 8'h00);
      cyc(2);
      @(negedge clk); ext_clk = 1'b1;
      @(negedge clk); peek16(v); chk("R5 async latency", v, 16'd1);
      cyc(2); ext_clk = 1'b0; cyc(3);
      for (int k = 0; k < 7; k++) ext_pulse();
      cyc(4);
      peek16(v);
      chk("R5 async edge count", v, 16'd8);

      // R7: overflow flag timing and clearing
      begin
         logic [15:0] last;
         logic        lastf, f;
         wr(2'd0, ctl(0, 0, 0, 2'd0, 0));
         wr(2'd2, 8'hFF);
         wr(2'd1, 8'hFC);
         wr(2'd0, ctl(1, 0, 0, 2'd0, 0));
         peek16(last); lastf = irq_flag; f = irq_flag;
         for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            peek16(v);
            f = irq_flag;
            if (v == 16'h0000) break;
            last = v; lastf = f;
         end
         chk("R7 value before wrap", last, 16'hFFFF);
         chk("R7 flag low before wrap", {15'd0, lastf}, 16'd0);
         chk("R7 flag set at wrap", {15'd0, f}, 16'd1);
      end
      cyc(10);
      wr(2'd3, 8'h01);
      rd(2'd3, v8);
      chk("R7 write one no effect", {8'h00, v8}, 16'h0001);
      wr(2'd3, 8'h00);
      rd(2'd3, v8);
      chk("R7 write zero clears", {8'h00, v8}, 16'h0000);

      // R9: direct access
      wr(2'd0, ctl(0, 0, 0, 2'd0, 0));
      wr(2'd2, 8'h5A);
      wr(2'd1, 8'hC3);
      rd(2'd2, v8); chk("R9 direct high", {8'h00, v8}, 16'h005A);
      rd(2'd1, v8); chk("R9 direct low", {8'h00, v8}, 16'h00C3);

      // R10/R11: buffered mode
      wr(2'd0, ctl(0, 0, 0, 2'd0, 1));
      wr(2'd2, 8'hAB);
      rd(2'd1, v8); chk("R11 low untouched", {8'h00, v8}, 16'h00C3);
      rd(2'd2, v8); chk("R11 high write buffered only", {8'h00, v8}, 16'h005A);
      wr(2'd2, 8'hAB);
      wr(2'd1, 8'hCD);
      rd(2'd1, v8); chk("R11 joint load low", {8'h00, v8}, 16'h00CD);
      rd(2'd2, v8); chk("R11 joint load high", {8'h00, v8}, 16'h00AB);

      // R10: capture across a carry
      wr(2'd2, 8'h01);
      wr(2'd1, 8'hFE);
      wr(2'd0, ctl(1, 0, 0, 2'd0, 1));
      n = 0;
      bus_addr = 2'd1; #1 v8 = bus_rdata;
      while (v8 != 8'hFF && n < 100) begin
         @(negedge clk);
         n++;
         bus_addr = 2'd1; #1 v8 = bus_rdata;
      end
      rd_now(2'd1, v8);
      chk("R10 captured low", {8'h00, v8}, 16'h00FF);
      cyc(20);
      rd(2'd2, v8);
      chk("R10 buffered high coherent", {8'h00, v8}, 16'h0001);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule